// File: doc/BRIEF.md
# Fast Page Mode DRAM Sequencer

The sequencer sits between a synchronous host and a 16-bit-wide asynchronous DRAM of 4,194,304 words. It turns each host word request into row and column strobe sequences. A row stays open after an access. A later request that falls in the same row then runs as a column-only cycle: CAS is toggled while RAS stays low, which is shorter than a full random cycle. The two bytes of a word have separate column strobes, so a write can touch only one byte.

Refresh is requested by the surrounding system on a plain request pin. The block grants it with a one-cycle acknowledge and then runs a CAS-before-RAS cycle. All DRAM timings are parameters counted in clock cycles. The user rounds them up from the nanosecond figures for the chosen clock period.

Host requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the address, write flag, byte enables and write data stable until that edge. `req_ready` is low while any strobe sequence is in progress. It is also low while a refresh request is pending, and whenever the open page is about to close. Read results appear with a one-cycle `rdata_valid` pulse. There is no back-pressure on that output.

Top module: `fpm_dram_seq`

## Requirements
- R1: The word address is split with the row in the upper bits and the column in the lower bits. With `REF8K`=1 (default) the row is address bits 21..9 (13 bits) and the column is bits 8..0. With `REF8K`=0 the row is bits 21..10 and the column is bits 9..0. The row is on `dram_addr` for at least one cycle before RAS falls and stays there until CAS is due. The column is on `dram_addr` one cycle before CAS falls.
- R2: A read drives both CAS lines low for `T_CAS` cycles (default 2), with OE_n low and WE_n high. The bus is sampled in the last CAS-low cycle. `rdata` then holds that word, and `rdata_valid` is high for exactly the following cycle.
- R3: A write is an early write. WE_n goes low one cycle before CAS falls. OE_n stays high for the whole write. `dram_dq_oe` is high only while a write CAS pulse is low, and during that time `dram_dq_out` carries the request's write data.
- R4: On a write, `req_be[1]` selects the upper byte (UCAS_n) and `req_be[0]` selects the lower byte (LCAS_n). Only the selected CAS lines pulse, so the other byte in memory is unchanged. A read pulses both lines.
- R5: When a row is open and the next request is in the same row, the request is accepted without RAS rising. It is served by a CAS-only cycle.
- R6: A request to a different row, or a pending refresh, closes the page. Before RAS falls again it stays high for at least `T_RP` cycles (default 3).
- R7: Refresh requested on `ref_req` takes priority over a host request presented in the same cycle. `ref_ack` is high for exactly one cycle. In that cycle both CAS lines are low while RAS is still high. RAS then falls for `T_RFR` cycles.
- R8: RAS never stays low for more than `T_RAS_MAX` cycles (default 64). Once another page cycle would exceed that limit, the page is closed even if same-row requests keep arriving.
- R9: `req_ready` is low while a strobe sequence is running. Exactly one request is taken per handshake.
- R10: After reset all strobes are high, `dram_dq_oe` and `rdata_valid` are low, and `req_ready` is high when no refresh is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this edge when valid |
| req_addr | input | 22 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Captured read word |
| rdata_valid | output | 1 | One-cycle pulse when `rdata` is new |
| ref_req | input | 1 | Refresh wanted |
| ref_ack | output | 1 | Refresh granted (one cycle) |
| dram_ras_n | output | 1 | Row strobe |
| dram_ucas_n | output | 1 | Upper-byte column strobe |
| dram_lcas_n | output | 1 | Lower-byte column strobe |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_in | input | 16 | Data from the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The hardest case to reach from the ports is the forced page close under R8. It only happens once a single row has been kept open long enough by back-to-back hits. The bench streams more than a dozen same-row requests with no gap. It then measures the longest RAS-low run and counts the extra activations. The refresh-versus-request collision of R7 is reached by raising `ref_req` and `req_valid` on the same idle cycle.

// File: rtl/fpm_seq_pkg.sv
package fpm_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // page closed, precharge met
    S_ROW,    // row address setup, RAS high
    S_RCD,    // RAS low, waiting before first CAS
    S_COL,    // column address setup, CAS high
    S_CAS,    // CAS pulse
    S_CP,     // CAS precharge
    S_OPEN,   // row open, waiting for a request
    S_PRE,    // RAS precharge
    S_RFC,    // refresh: CAS low ahead of RAS
    S_RFR     // refresh: RAS low
  } seq_state_e;
endpackage

// File: rtl/fpm_addr_map.sv
module fpm_addr_map #(
  parameter int ADDR_W = 22,
  parameter int ROW_W  = 13,
  parameter int COL_W  = ADDR_W - ROW_W
) (
  input  logic [ADDR_W-1:0] word_addr,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign row = word_addr[ADDR_W-1 -: ROW_W];
  assign col = word_addr[COL_W-1:0];
endmodule

// File: rtl/fpm_cycle_timer.sv
module fpm_cycle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
  assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_ras_guard.sv
module fpm_ras_guard #(
  parameter int TW    = 8,
  parameter int LIMIT = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic room_ok
);
  logic [TW-1:0] low_q;
  always_ff @(posedge clk) begin
    if (!rst_n || ras_n)  low_q <= '0;
    else if (low_q != '1) low_q <= low_q + 1'b1;
  end
  assign room_ok = (low_q <= TW'(LIMIT));
endmodule

// File: rtl/fpm_dram_seq.sv
module fpm_dram_seq
  import fpm_seq_pkg::*;
#(
  parameter bit REF8K     = 1'b1,
  parameter int ADDR_W    = 22,
  parameter int DA_W      = 13,
  parameter int DQ_W      = 16,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 3,
  parameter int T_RFR     = 4,
  parameter int T_RAS_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DQ_W/8-1:0] req_be,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic [DQ_W-1:0]   rdata,
  output logic              rdata_valid,
  input  logic              ref_req,
  output logic              ref_ack,
  output logic              dram_ras_n,
  output logic              dram_ucas_n,
  output logic              dram_lcas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DA_W-1:0]   dram_addr,
  output logic [DQ_W-1:0]   dram_dq_out,
  input  logic [DQ_W-1:0]   dram_dq_in,
  output logic              dram_dq_oe
);
  localparam int ROW_W    = REF8K ? DA_W : DA_W - 1;
  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int NB       = DQ_W / 8;
  localparam int TW       = $clog2(T_RAS_MAX + 1) + 1;
  localparam int PAGE_LEN = 1 + T_CAS + T_CP;
  localparam int LO_LIMIT = T_RAS_MAX - PAGE_LEN - 2;

  seq_state_e st_q, st_d;
  logic [ROW_W-1:0] in_row, row_q;
  logic [COL_W-1:0] in_col, col_q;
  logic             we_q;
  logic [NB-1:0]    be_q;
  logic [DQ_W-1:0]  wdata_q;
  logic             accept, hit, room_ok, t_done, t_load, capture;
  logic [TW-1:0]    t_val;
  logic [NB-1:0]    cas_low;

  fpm_addr_map #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_map (
    .word_addr(req_addr), .row(in_row), .col(in_col));

  fpm_cycle_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done));

  fpm_ras_guard #(.TW(TW), .LIMIT(LO_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .room_ok(room_ok));

  assign hit = (in_row == row_q);

  always_comb begin
    st_d      = st_q;
    req_ready = 1'b0;
    unique case (st_q)
      S_IDLE: if (ref_req) st_d = S_RFC;
              else begin
                req_ready = 1'b1;
                if (req_valid) st_d = S_ROW;
              end
      S_ROW:  st_d = S_RCD;
      S_RCD:  if (t_done) st_d = S_COL;
      S_COL:  st_d = S_CAS;
      S_CAS:  if (t_done) st_d = S_CP;
      S_CP:   if (t_done) st_d = S_OPEN;
      S_OPEN: if (ref_req || !room_ok) st_d = S_PRE;
              else if (req_valid) begin
                if (hit) begin
                  req_ready = 1'b1;
                  st_d      = S_COL;
                end else st_d = S_PRE;
              end
      S_PRE:  if (t_done) st_d = S_IDLE;
      S_RFC:  st_d = S_RFR;
      S_RFR:  if (t_done) st_d = S_PRE;
      default: st_d = S_IDLE;
    endcase
  end

  assign accept  = req_valid && req_ready;
  assign t_load  = (st_d != st_q);
  assign capture = (st_q == S_CAS) && t_done && !we_q;

  always_comb begin
    unique case (st_d)
      S_RCD:   t_val = TW'(T_RCD - 1);
      S_CAS:   t_val = TW'(T_CAS - 1);
      S_CP:    t_val = TW'(T_CP - 1);
      S_PRE:   t_val = TW'(T_RP - 1);
      S_RFR:   t_val = TW'(T_RFR - 1);
      default: t_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      be_q        <= '0;
      wdata_q     <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      st_q        <= st_d;
      rdata_valid <= capture;
      if (capture) rdata <= dram_dq_in;
      if (accept) begin
        row_q   <= in_row;
        col_q   <= in_col;
        we_q    <= req_we;
        be_q    <= req_be;
        wdata_q <= req_wdata;
      end
    end
  end

  // one column strobe per byte lane
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign cas_low[g] = (st_q == S_RFC) || (st_q == S_RFR) ||
                        ((st_q == S_CAS) && (!we_q || be_q[g]));
  end

  assign dram_lcas_n = !cas_low[0];
  assign dram_ucas_n = !cas_low[NB-1];
  assign dram_ras_n  = !(st_q inside {S_RCD, S_COL, S_CAS, S_CP, S_OPEN, S_RFR});
  assign dram_we_n   = !(we_q && (st_q inside {S_COL, S_CAS}));
  assign dram_oe_n   = !(!we_q && st_q == S_CAS);
  assign dram_dq_oe  = we_q && (st_q == S_CAS) && (be_q != '0);
  assign dram_dq_out = wdata_q;
  assign ref_ack     = (st_q == S_RFC);

  always_comb begin
    dram_addr = '0;
    if (st_q inside {S_COL, S_CAS, S_CP, S_OPEN}) dram_addr[COL_W-1:0] = col_q;
    else                                          dram_addr[ROW_W-1:0] = row_q;
  end
endmodule

// File: rtl/fpm_dram_seq_chk.sv
module fpm_dram_seq_chk #(
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 64
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rdata_valid,
  input logic ref_ack,
  input logic dram_ras_n,
  input logic dram_ucas_n,
  input logic dram_lcas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  localparam int HW = $clog2(T_RP + 1) + 1;
  localparam int LW = $clog2(T_RAS_MAX + 1) + 1;
  logic [HW-1:0] hi_run;
  logic [LW-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= HW'(T_RP);
      lo_run <= '0;
    end else begin
      if (dram_ras_n) begin
        lo_run <= '0;
        if (hi_run < HW'(T_RP)) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run != '1) lo_run <= lo_run + 1'b1;
      end
    end
  end

  a_r7_cas_first_only_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ucas_n && dram_ras_n) |-> ref_ack);
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);
  a_r3_drive_in_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n && !(dram_ucas_n && dram_lcas_n)));
  a_r2_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (dram_we_n && !dram_dq_oe && !dram_ucas_n && !dram_lcas_n));
  a_r4_split_cas_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ucas_n != dram_lcas_n) |-> !dram_we_n);
  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> ($past(!dram_oe_n) && $past(!rdata_valid)));
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_run >= HW'(T_RP)));
  a_r8_ras_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (lo_run < LW'(T_RAS_MAX)));
  a_r9_ready_not_mid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ucas_n && dram_lcas_n));
endmodule

bind fpm_dram_seq fpm_dram_seq_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rdata_valid(rdata_valid),
  .ref_ack(ref_ack), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
  .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
  .dram_dq_oe(dram_dq_oe));

// File: tb/fpm_dram_seq_bench.sv
module fpm_dram_seq_bench;
  localparam int CLK_P  = 10;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 9;
  localparam int T_RP   = 3;
  localparam int RASMAX = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, dram_dq_in;
  logic req_ready, rdata_valid, ref_ack;
  logic [15:0] rdata, dram_dq_out;
  logic dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [12:0] dram_addr;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  fpm_dram_seq u_fpm_dram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .ref_req(ref_req), .ref_ack(ref_ack),
    .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in), .dram_dq_oe(dram_dq_oe));

  // ---- DRAM model and strobe monitor ----
  logic [15:0] mem [int];
  logic [ROW_W-1:0] m_row = '0;
  logic p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1;
  int act_cnt = 0, cbr_cnt = 0, lo_len = 0, max_lo = 0, hi_len = 100, min_pre = 100;

  function automatic logic [15:0] peek(int k);
    return mem.exists(k) ? mem[k] : (k[15:0] ^ 16'h5A5A);
  endfunction

  always_comb dram_dq_in = peek(int'({m_row, dram_addr[COL_W-1:0]}));

  always @(posedge clk) begin
    int k;
    logic [15:0] w;
    k = int'({m_row, dram_addr[COL_W-1:0]});
    if (p_ras && !dram_ras_n) begin
      m_row <= dram_addr[ROW_W-1:0];
      act_cnt++;
      if (!p_u && !p_l) cbr_cnt++;
      if (hi_len < min_pre) min_pre = hi_len;
    end
    if (!dram_ras_n && !dram_we_n && ((p_u && !dram_ucas_n) || (p_l && !dram_lcas_n))) begin
      w = peek(k);
      if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
      if (!dram_lcas_n) w[7:0]  = dram_dq_out[7:0];
      mem[k] = w;
    end
    if (dram_ras_n) begin lo_len = 0; hi_len++; end
    else begin hi_len = 0; lo_len++; if (lo_len > max_lo) max_lo = lo_len; end
    p_ras <= dram_ras_n; p_u <= dram_ucas_n; p_l <= dram_lcas_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [21:0] a, input logic we, input logic [1:0] be,
                       input logic [15:0] d);
    @(negedge clk);
    req_addr = a; req_we = we; req_be = be; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_word(input logic [21:0] a, output logic [15:0] d);
    issue(a, 1'b0, 2'b11, 16'h0);
    d = 16'hxxxx;
    for (int i = 0; i < 60; i++) begin
      if (rdata_valid) begin d = rdata; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R10 ras_n", dram_ras_n, 1);
    check("R10 cas_n", {dram_ucas_n, dram_lcas_n}, 2'b11);
    check("R10 we/oe", {dram_we_n, dram_oe_n}, 2'b11);
    check("R10 dq_oe/rvalid", {dram_dq_oe, rdata_valid}, 0);
    check("R10 ready", req_ready, 1);
  endtask

  task automatic t_write_read();
    logic [15:0] d;
    issue(22'h12345, 1'b1, 2'b11, 16'hBEEF);
    read_word(22'h12345, d);
    check("R3 write then read", d, 16'hBEEF);
    check("R1 row/col split lands at word address", peek(int'(22'h12345)), 16'hBEEF);
    read_word(22'h00077, d);
    check("R2 read untouched word", d, 16'h0077 ^ 16'h5A5A);
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    issue(22'h20010, 1'b1, 2'b11, 16'h1122);
    issue(22'h20010, 1'b1, 2'b10, 16'hAAFF);
    read_word(22'h20010, d);
    check("R4 upper-only write", d, 16'hAA22);
    issue(22'h20010, 1'b1, 2'b01, 16'hFF55);
    read_word(22'h20010, d);
    check("R4 lower-only write", d, 16'hAA55);
  endtask

  task automatic t_page_hit();
    logic [15:0] d;
    int a0;
    read_word(22'h30000, d);
    a0 = act_cnt;
    read_word(22'h30005, d);
    check("R5 same row no new activation", act_cnt - a0, 0);
    check("R5 hit data", d, 16'h0005 ^ 16'h5A5A);
  endtask

  task automatic t_row_miss();
    logic [15:0] d;
    int a0;
    a0 = act_cnt;
    read_word(22'h3FE00, d);
    check("R6 miss reactivates", act_cnt - a0, 1);
    check("R6 precharge length", (min_pre >= T_RP), 1);
  endtask

  task automatic t_backpressure();
    logic [15:0] d;
    logic busy_ready = 1'b0;
    issue(22'h05000, 1'b0, 2'b11, 16'h0);
    req_addr = 22'h0A000; req_we = 1'b0; req_be = 2'b11; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin #1; busy_ready |= req_ready; @(negedge clk); end
    req_valid = 1'b0;
    check("R9 ready low during sequence", busy_ready, 0);
    read_word(22'h0A000, d);
    check("R9 held request served once", d, 16'hA000 ^ 16'h5A5A);
  endtask

  task automatic t_refresh();
    logic [15:0] d;
    int c0;
    c0 = cbr_cnt;
    repeat (12) @(negedge clk);
    ref_req = 1'b1; req_valid = 1'b1; req_addr = 22'h11111; req_we = 1'b0; req_be = 2'b11;
    #1;
    check("R7 refresh wins over request", req_ready, 0);
    for (int i = 0; i < 20 && !ref_ack; i++) @(negedge clk);
    check("R7 ack seen", ref_ack, 1);
    ref_req = 1'b0;
    req_valid = 1'b0;
    read_word(22'h11111, d);
    check("R7 CAS before RAS", cbr_cnt - c0, 1);
    check("R7 request after refresh", d, 16'h1111 ^ 16'h5A5A);
  endtask

  task automatic t_ras_limit();
    int a0;
    a0 = act_cnt;
    max_lo = 0;
    for (int i = 0; i < 16; i++) issue(22'h2A000 + 22'(i), 1'b1, 2'b11, 16'(i));
    repeat (10) @(negedge clk);
    check("R8 ras low bounded", (max_lo <= RASMAX), 1);
    check("R8 page forced closed", (act_cnt - a0 >= 2), 1);
    check("R8 last hit written", peek(int'(22'h2A00F)), 16'h000F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_write_read();
    t_bytes();
    t_page_hit();
    t_row_miss();
    t_backpressure();
    t_refresh();
    t_ras_limit();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule